// File: doc/BRIEF.md
# Serial Clock Phase Timer

This block produces the clock line waveform for a two-wire serial bus master. A low phase and a high phase are each timed by a programmable 9-bit count of ticks, and a tick comes on every functional clock or on every second one, as a select input chooses. The block pulls the open-drain clock line low for the low phase and lets it go for the high phase. It gives a byte engine three one-cycle markers: the falling edge, the start of the counted high time, and a sampling point in the middle of the high time.

The low phase is timed from the cycle in which the block starts to pull the line low. The high phase is timed only once the line, seen through a synchronizer, actually reads high. The time the line takes to rise, and any time another device holds it low (clock stretching), therefore come on top of the programmed high time. When the block is enabled from idle it starts with a counted high phase, so a byte engine that drops the data line together with the enable gets a START hold time equal to the high count. Writing the count registers and sequencing the bytes belong to neighbouring blocks.

Top module: `scl_timing_gen`

## Requirements
- R1: While `enable` is low, `scl_drive_low` is 0 and all three strobes are 0. From the clock cycle after `enable` is sampled low the line is released, and it stays released until the block is enabled again.
- R2: A low phase lasts max(Le*d, 3) clock cycles. Le is `low_count` (a 9-bit unsigned value). d is 1 when `prescale_sel` is 0 and 2 when it is 1.
- R3: If the line follows the drive with no delay, a released phase between two low phases lasts He*d + 3 cycles, where He is `high_count`. Each further cycle that another device holds the line low after release lengthens the phase by one cycle.
- R4: A count of 0 in `low_count` or `high_count` is timed as a count of 1.
- R5: When `prescale_sel` is 1, a tick comes on every second clock, so each counted phase takes twice as long as it does with `prescale_sel` at 0.
- R6: After `enable` goes high from idle while the line is high, the line is first pulled low He*d + 1 cycles after the first cycle in which `enable` is high.
- R7: `fall_strobe` is high only in the first cycle of each low phase, exactly once per low phase. `rise_strobe` and `sample_strobe` are each high exactly once per released phase, and only while the line is released.
- R8: All 9 bits of each count are used, so counts of 256 and above give periods longer than any 8-bit value could give.
- R9: A low phase does not end until the synchronized line has read low. Even the shortest programmed low count therefore keeps the line pulled low for at least 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the clock generator; low releases the line and clears the timers |
| low_count | input | 9 | Low-phase length in ticks (0 is taken as 1) |
| high_count | input | 9 | High-phase length in ticks, counted after the line reads high (0 is taken as 1) |
| prescale_sel | input | 1 | 0: one tick per clock; 1: one tick per two clocks |
| scl_in | input | 1 | Sensed level of the clock line |
| scl_drive_low | output | 1 | 1 pulls the clock line low |
| fall_strobe | output | 1 | One-cycle marker at the start of each low phase |
| rise_strobe | output | 1 | One-cycle marker when the line is first seen high and high timing starts |
| sample_strobe | output | 1 | One-cycle marker at the middle of the counted high time |

## Verification
The bench builds the block with its default parameters: 9-bit counts and a two-flop synchronizer. With these defaults the fixed part of each released phase is three cycles, and counts of up to 511 fit in a run of a few thousand cycles. The bench models the open-drain line with a delay it can set, which lets it reach clock stretching, both tick rates, zero counts, the 3-cycle minimum low phase and counts above 255 within one short run.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  // Phase of the serial clock generator
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_HWAIT = 2'd1,
    PH_HCNT  = 2'd2,
    PH_LCNT  = 2'd3
  } phase_e;
endpackage

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= line_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign line_sync = chain_q[STAGES-1];
endmodule

// File: rtl/scl_tick_div.sv
module scl_tick_div (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic half_rate,
  output logic tick
);
  logic phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= 1'b0;
    else if (restart) phase_q <= 1'b0;
    else              phase_q <= ~phase_q;
  end

  assign tick = half_rate ? phase_q : 1'b1;
endmodule

// File: rtl/scl_phase_counter.sv
module scl_phase_counter #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] target,
  output logic             expired,
  output logic             at_mid
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] cnt_plus;

  assign cnt_plus = {1'b0, cnt_q} + EXT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (clear)                  cnt_q <= '0;
    else if (tick && cnt_q < target) cnt_q <= cnt_q + CNT_W'(1);
  end

  // Saturated, or the current tick completes the count
  assign expired = (cnt_q >= target) || (tick && (cnt_plus >= {1'b0, target}));
  assign at_mid  = tick && (cnt_q == (target >> 1));
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter int CNT_W       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] low_count,
  input  logic [CNT_W-1:0] high_count,
  input  logic             prescale_sel,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             fall_strobe,
  output logic             rise_strobe,
  output logic             sample_strobe
);
  import scl_gen_pkg::*;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_e           phase_q, phase_d;
  logic             line_hi;
  logic             tick;
  logic             phase_change;
  logic             cnt_clear;
  logic             counting;
  logic             expired;
  logic             at_mid;
  logic [CNT_W-1:0] low_eff, high_eff, target;
  logic             fall_q, rise_q;

  scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_in  (scl_in),
    .line_sync(line_hi)
  );

  assign phase_change = (phase_d != phase_q);
  assign cnt_clear    = phase_change || (phase_q == PH_IDLE);
  assign counting     = (phase_q == PH_HCNT) || (phase_q == PH_LCNT);

  scl_tick_div u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (cnt_clear),
    .half_rate(prescale_sel),
    .tick     (tick)
  );

  // A zero count is timed as one tick
  assign low_eff  = (low_count  == '0) ? ONE : low_count;
  assign high_eff = (high_count == '0) ? ONE : high_count;
  assign target   = (phase_q == PH_LCNT) ? low_eff : high_eff;

  scl_phase_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (cnt_clear),
    .tick   (tick && counting),
    .target (target),
    .expired(expired),
    .at_mid (at_mid)
  );

  always_comb begin
    phase_d = phase_q;
    if (!enable) begin
      phase_d = PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE:  phase_d = PH_HWAIT;
        PH_HWAIT: if (line_hi) phase_d = PH_HCNT;
        PH_HCNT:  if (expired) phase_d = PH_LCNT;
        PH_LCNT:  if (expired && !line_hi) phase_d = PH_HWAIT;
        default:  phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      fall_q  <= 1'b0;
      rise_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      fall_q  <= (phase_d == PH_LCNT) && (phase_q != PH_LCNT);
      rise_q  <= (phase_d == PH_HCNT) && (phase_q != PH_HCNT);
    end
  end

  assign scl_drive_low = (phase_q == PH_LCNT);
  assign fall_strobe   = fall_q;
  assign rise_strobe   = rise_q;
  assign sample_strobe = (phase_q == PH_HCNT) && at_mid;
endmodule

// File: rtl/scl_timing_gen_checker.sv
module scl_timing_gen_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic scl_drive_low,
  input logic fall_strobe,
  input logic rise_strobe,
  input logic sample_strobe
);
  logic [11:0] low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       low_run_q <= '0;
    else if (!scl_drive_low)          low_run_q <= '0;
    else if (low_run_q != 12'hFFF)    low_run_q <= low_run_q + 12'd1;
  end

  assert_release_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_drive_low && !fall_strobe && !rise_strobe));

  assert_fall_at_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |-> fall_strobe);

  assert_fall_only_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fall_strobe |-> scl_drive_low);

  assert_rise_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rise_strobe |-> !scl_drive_low);

  assert_sample_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> !scl_drive_low);

  assert_low_min_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_drive_low) && $past(enable)) |-> (low_run_q >= 12'd3));
endmodule

bind scl_timing_gen scl_timing_gen_checker u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .scl_drive_low(scl_drive_low),
  .fall_strobe  (fall_strobe),
  .rise_strobe  (rise_strobe),
  .sample_strobe(sample_strobe)
);

// File: tb/test_scl_timing_gen.sv
module test_scl_timing_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [8:0] low_count = 9'd0;
  logic [8:0] high_count = 9'd0;
  logic       prescale_sel = 1'b0;
  logic       scl_line = 1'b1;
  logic       scl_drive_low, fall_strobe, rise_strobe, sample_strobe;

  int stretch_cfg = 0;
  int stretch_left = 0;
  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  always #4ns clk = ~clk;

  scl_timing_gen i_scl_timing_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .low_count    (low_count),
    .high_count   (high_count),
    .prescale_sel (prescale_sel),
    .scl_in       (scl_line),
    .scl_drive_low(scl_drive_low),
    .fall_strobe  (fall_strobe),
    .rise_strobe  (rise_strobe),
    .sample_strobe(sample_strobe)
  );

  // Open-drain line model: another device may hold it low after release
  initial forever begin
    @(negedge clk);
    scl_line = !(scl_drive_low || stretch_left != 0);
    if (scl_drive_low)         stretch_left = stretch_cfg;
    else if (stretch_left > 0) stretch_left = stretch_left - 1;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below 150000", cycles);
        finish_run();
      end
    end
  end

  // Last sampled values carried between runs
  logic last_dl;
  int   last_f, last_r, last_s;

  task automatic sample_now();
    @(negedge clk);
    last_dl = scl_drive_low;
    last_f  = int'(fall_strobe);
    last_r  = int'(rise_strobe);
    last_s  = int'(sample_strobe);
  endtask

  task automatic next_run(output int len, output int nf, output int nr, output int ns);
    logic lvl;
    lvl = last_dl;
    len = 1; nf = last_f; nr = last_r; ns = last_s;
    forever begin
      sample_now();
      if (last_dl != lvl) break;
      len++; nf += last_f; nr += last_r; ns += last_s;
      if (len > 5000) break;
    end
  endtask

  // Fields: low[28:20] high[19:11] sel[10] stretch[9:0]
  localparam int NV = 6;
  localparam logic [28:0] VEC [NV] = '{
    {9'd5,   9'd4,   1'b0, 10'd0},
    {9'd0,   9'd0,   1'b0, 10'd0},
    {9'd6,   9'd3,   1'b1, 10'd0},
    {9'd300, 9'd260, 1'b0, 10'd0},
    {9'd4,   9'd5,   1'b0, 10'd7},
    {9'd1,   9'd2,   1'b1, 10'd2}
  };

  initial begin
    int len, nf, nr, ns;
    int le, he, d, exp_low, exp_high;

    repeat (3) @(negedge clk);
    check("R1 reset drive", int'(scl_drive_low), 0);
    check("R1 reset strobes", int'(fall_strobe | rise_strobe | sample_strobe), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      low_count    = VEC[i][28:20];
      high_count   = VEC[i][19:11];
      prescale_sel = VEC[i][10];
      stretch_cfg  = int'(VEC[i][9:0]);
      d  = prescale_sel ? 2 : 1;
      le = (low_count == 0) ? 1 : int'(low_count);    // R4
      he = (high_count == 0) ? 1 : int'(high_count);
      exp_low  = (le * d > 3) ? le * d : 3;            // R2, R9
      exp_high = he * d + 3 + stretch_cfg;             // R3

      enable = 1'b1;
      sample_now();
      next_run(len, nf, nr, ns);
      check($sformatf("R6 start hold v%0d", i), len, he * d + 1);
      next_run(len, nf, nr, ns);
      check($sformatf("R2 R5 R8 R9 low v%0d", i), len, exp_low);
      check($sformatf("R7 fall count v%0d", i), nf, 1);
      next_run(len, nf, nr, ns);
      check($sformatf("R3 R4 R5 R8 high v%0d", i), len, exp_high);
      check($sformatf("R7 rise count v%0d", i), nr, 1);
      check($sformatf("R7 sample count v%0d", i), ns, 1);
      next_run(len, nf, nr, ns);
      check($sformatf("R2 second low v%0d", i), len, exp_low);
      enable = 1'b0;
      stretch_cfg = 0;
      repeat (20) @(negedge clk);
    end

    // R1: disable in the middle of a low phase
    low_count = 9'd40; high_count = 9'd2; prescale_sel = 1'b0;
    enable = 1'b1;
    while (!scl_drive_low) @(negedge clk);
    repeat (5) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R1 release after disable", int'(scl_drive_low), 0);
    begin
      int act_cnt;
      act_cnt = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        act_cnt += int'(scl_drive_low | fall_strobe | rise_strobe | sample_strobe);
      end
      check("R1 quiet while disabled", act_cnt, 0);
    end

    finish_run();
  end
endmodule